// File: doc/BRIEF.md
# Byte/Word Flash Bus Front-End

This block sits between the pins of a simulated parallel flash device and its internal logic. It samples the active-low chip enable, output enable and write enable strobes on a system clock. Each clock it classifies the bus as a read, a write or idle. It forms the internal address and places array data on the data lanes. When a write ends, it hands the write to a command port as a single-cycle strobe.

A width-select pin picks the data path. When the pin is high, all sixteen lanes carry a word. When it is low, only the low eight lanes carry data. Lanes 14 to 8 stay undriven, and lane 15 turns into the lowest address bit, choosing the high or low byte of the addressed word. The interface comes out of reset in read-array mode, so a read returns array contents with no command needed first. The address space has four banks, selected by the two top word-address bits. The bank travels with every command so that command logic can track each bank's state.

Top module: `fbf_bus_frontend`

## Requirements
- R1: After reset no lane is enabled and no command strobe is present, and the first read cycle returns array data with no command needed first (read-array mode).
- R2: A read cycle is recognised only when chip enable and output enable are both low and write enable is high; lane outputs reflect it one clock after the sampling edge.
- R3: In word mode (width-select high) a read enables all 16 lanes and drives the 16-bit array word at the word address, which is also presented on the array address port.
- R4: In byte mode (width-select low) a read enables only lanes 7..0 (lane-enable value 0x00FF); lanes 7..0 carry array bits 7..0 when lane 15 reads 0 and array bits 15..8 when it reads 1; data outputs 15..8 are zero.
- R5: In byte mode, lanes 14..8 and lane 15 are never enabled, whatever the cycle type.
- R6: With chip enable high, or with output enable and write enable both low, no lane is enabled and no command strobe is produced.
- R7: A write cycle (chip enable and write enable low, output enable high) enables no lane. One clock after the cycle ends, a one-clock strobe is raised. It carries the last sampled write: the byte address is {word address, lsb}, where lsb is lane 15 in byte mode and 0 in word mode. The data is the full 16-bit word in word mode, or {8'h00, lanes 7..0} in byte mode. A flag is set to 1 for byte mode.
- R8: The command bank field equals the two top bits of the written word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wide_n | input | 1 | Width select: 1 word mode, 0 byte mode |
| addr | input | ADDR_W | Word address |
| dq_i | input | WORD_W | Data lanes as seen at the pins (lane 15 is the byte address bit in byte mode) |
| dq_o | output | WORD_W | Data lanes driven by the device |
| dq_oe | output | WORD_W | Per-lane output enable |
| arr_addr | output | ADDR_W | Word address to the storage array |
| arr_rdata | input | WORD_W | Word read from the storage array |
| cmd_valid | output | 1 | One-clock strobe for a finished write |
| cmd_addr | output | ADDR_W+1 | Byte address of the write |
| cmd_data | output | WORD_W | Write data |
| cmd_byte | output | 1 | Write was made in byte mode |
| cmd_bank | output | 2 | Bank of the write |

## Verification
The assertions take it for granted that the pin strobes are already synchronous to the clock and hold steady for at least one full clock per cycle type. They also assume that the array answers combinationally within the same clock. The bench keeps to this by changing every pin only on the falling clock edge and by modelling the array as an arithmetic function of the address. It holds each write for one clock and follows it with idle before any other cycle, so each strobe can be traced back to exactly one write.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/fbf_cycle_decode.sv
module fbf_cycle_decode
  import fbf_pkg::*;
(
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output cyc_e cyc
);
  always_comb begin
    cyc = CYC_IDLE;
    if (!ce_n && !oe_n && we_n)
      cyc = CYC_READ;
    else if (!ce_n && !we_n && oe_n)
      cyc = CYC_WRITE;
  end
endmodule

// File: rtl/fbf_read_lanes.sv
module fbf_read_lanes
  import fbf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc,
  input  logic              byte_mode,
  input  logic              lsb,
  input  logic [WORD_W-1:0] arr_rdata,
  output logic [WORD_W-1:0] dq_o,
  output logic [WORD_W-1:0] dq_oe
);
  localparam int LANE_W = WORD_W / 2;

  logic              is_rd;
  logic [WORD_W-1:0] oe_d;
  logic [WORD_W-1:0] oe_q;
  logic [WORD_W-1:0] do_d;
  logic [WORD_W-1:0] do_q;
  logic              do_en;

  assign is_rd = (cyc == CYC_READ);
  assign do_en = is_rd;

  for (genvar i = 0; i < WORD_W; i++) begin : g_lane_oe
    if (i < LANE_W) begin : g_low
      assign oe_d[i] = is_rd;
    end else begin : g_high
      assign oe_d[i] = is_rd & ~byte_mode;
    end
  end

  always_comb begin
    if (!byte_mode)
      do_d = arr_rdata;
    else if (lsb)
      do_d = {{LANE_W{1'b0}}, arr_rdata[WORD_W-1:LANE_W]};
    else
      do_d = {{LANE_W{1'b0}}, arr_rdata[LANE_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= '0;
      do_q <= '0;
    end else begin
      oe_q <= oe_d;
      if (do_en)
        do_q <= do_d;
    end
  end

  assign dq_o  = do_q;
  assign dq_oe = oe_q;

  // R5
  byte_upper_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |=> (dq_oe[WORD_W-1:LANE_W] == '0));

  // R3
  word_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && !byte_mode) |=> (&dq_oe));

  // R6
  no_drive_off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> (dq_oe == '0));
endmodule

// File: rtl/fbf_write_capture.sv
module fbf_write_capture
  import fbf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc,
  input  logic              byte_mode,
  input  logic              lsb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dq_i,
  output logic              cmd_valid,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [WORD_W-1:0] cmd_data,
  output logic              cmd_byte,
  output logic [BANK_W-1:0] cmd_bank
);
  localparam int LANE_W = WORD_W / 2;

  logic              is_wr;
  logic              wr_q;
  logic              valid_d;
  logic              valid_q;
  logic              cap_en;
  logic [ADDR_W:0]   cap_addr_d;
  logic [ADDR_W:0]   cap_addr_q;
  logic [WORD_W-1:0] cap_data_d;
  logic [WORD_W-1:0] cap_data_q;
  logic              cap_byte_q;

  assign is_wr  = (cyc == CYC_WRITE);
  assign cap_en = is_wr;

  always_comb begin
    valid_d    = wr_q & ~is_wr;
    cap_addr_d = {addr, byte_mode & lsb};
    if (byte_mode)
      cap_data_d = {{LANE_W{1'b0}}, dq_i[LANE_W-1:0]};
    else
      cap_data_d = dq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q       <= 1'b0;
      valid_q    <= 1'b0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
      cap_byte_q <= 1'b0;
    end else begin
      wr_q    <= is_wr;
      valid_q <= valid_d;
      if (cap_en) begin
        cap_addr_q <= cap_addr_d;
        cap_data_q <= cap_data_d;
        cap_byte_q <= byte_mode;
      end
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_addr  = cap_addr_q;
  assign cmd_data  = cap_data_q;
  assign cmd_byte  = cap_byte_q;
  assign cmd_bank  = cap_addr_q[ADDR_W:ADDR_W-BANK_W+1];

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R7
  strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(cyc, 2) == CYC_WRITE && $past(cyc) != CYC_WRITE));
endmodule

// File: rtl/fbf_bus_frontend.sv
module fbf_bus_frontend
  import fbf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              wide_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dq_i,
  output logic [WORD_W-1:0] dq_o,
  output logic [WORD_W-1:0] dq_oe,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [WORD_W-1:0] arr_rdata,
  output logic              cmd_valid,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [WORD_W-1:0] cmd_data,
  output logic              cmd_byte,
  output logic [1:0]        cmd_bank
);
  localparam int BANK_W = 2;

  logic rst_s1;
  logic rst_s2;
  logic byte_mode;
  logic lsb;
  cyc_e cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign byte_mode = ~wide_n;
  assign lsb       = dq_i[WORD_W-1];
  assign arr_addr  = addr;

  fbf_cycle_decode u_dec (
    .ce_n (ce_n),
    .oe_n (oe_n),
    .we_n (we_n),
    .cyc  (cyc)
  );

  fbf_read_lanes #(.WORD_W(WORD_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_s2),
    .cyc       (cyc),
    .byte_mode (byte_mode),
    .lsb       (lsb),
    .arr_rdata (arr_rdata),
    .dq_o      (dq_o),
    .dq_oe     (dq_oe)
  );

  fbf_write_capture #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .BANK_W (BANK_W)
  ) u_wr (
    .clk       (clk),
    .rst_n     (rst_s2),
    .cyc       (cyc),
    .byte_mode (byte_mode),
    .lsb       (lsb),
    .addr      (addr),
    .dq_i      (dq_i),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_byte  (cmd_byte),
    .cmd_bank  (cmd_bank)
  );

  // R6
  clash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    (!ce_n && !oe_n && !we_n) |=> (dq_oe == '0));
endmodule

// File: tb/tb_fbf_bus_frontend.sv
module tb_fbf_bus_frontend;
  localparam int AW = 8;
  localparam int WW = 16;

  logic          clk;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, wide_n;
  logic [AW-1:0] addr;
  logic [WW-1:0] dq_i;
  logic [WW-1:0] dq_o, dq_oe;
  logic [AW-1:0] arr_addr;
  logic [WW-1:0] arr_rdata;
  logic          cmd_valid;
  logic [AW:0]   cmd_addr;
  logic [WW-1:0] cmd_data;
  logic          cmd_byte;
  logic [1:0]    cmd_bank;

  int checks;
  int fails;
  bit done;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [WW-1:0] stub(input logic [AW-1:0] a);
    return {a ^ 8'h5A, a + 8'd3};
  endfunction

  assign arr_rdata = stub(arr_addr);

  fbf_bus_frontend #(.ADDR_W(AW), .WORD_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wide_n(wide_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_byte(cmd_byte),
    .cmd_bank(cmd_bank)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pins(input logic c, input logic o, input logic w, input logic wd,
                      input logic [AW-1:0] a, input logic [WW-1:0] d);
    ce_n = c; oe_n = o; we_n = w; wide_n = wd; addr = a; dq_i = d;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [WW-1:0] w;
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0;
    pins(1, 1, 1, 1, '0, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset lane enables", dq_oe, 0);
    chk("R1 reset strobe", cmd_valid, 0);

    // R1: first read after reset returns array data
    pins(0, 0, 1, 1, 8'h10, '0);
    @(negedge clk);
    chk("R1 first read enables", dq_oe, 16'hFFFF);
    chk("R1 first read data", dq_o, stub(8'h10));

    // R2 R3 R4: sweep every address in word mode and both byte halves
    for (int a = 0; a < 256; a++) begin
      for (int m = 0; m < 3; m++) begin
        pins(0, 0, 1, (m == 0), a[AW-1:0], (m == 2) ? 16'h8000 : 16'h0000);
        #1;
        chk("R3 array address", arr_addr, a);
        @(negedge clk);
        w = stub(a[AW-1:0]);
        if (m == 0) begin
          chk("R3 word enables", dq_oe, 16'hFFFF);
          chk("R3 word data", dq_o, w);
        end else begin
          chk("R4 byte enables", dq_oe, 16'h00FF);
          chk("R4 byte data", dq_o, (m == 2) ? {8'h00, w[15:8]} : {8'h00, w[7:0]});
        end
      end
    end

    // R2: read ends -> lanes released one clock later
    pins(1, 1, 1, 1, '0, '0);
    @(negedge clk);
    chk("R2 release after read", dq_oe, 0);

    // R7 R8: writes in word mode and both byte halves
    for (int a = 0; a < 64; a++) begin
      for (int m = 0; m < 3; m++) begin
        logic [AW-1:0] wa;
        logic [WW-1:0] wd;
        wa = AW'(a * 4 + 1);
        wd = {a[7:0] ^ 8'h3C, ~a[7:0]};
        if (m == 2) wd[15] = 1'b1;
        if (m == 1) wd[15] = 1'b0;
        pins(1, 1, 0, (m == 0), wa, wd);
        ce_n = 1'b0;
        @(negedge clk);
        chk("R7 no drive during write", dq_oe, 0);
        chk("R7 no strobe during write", cmd_valid, 0);
        pins(1, 1, 1, 1, '0, '0);
        @(negedge clk);
        chk("R7 strobe raised", cmd_valid, 1);
        chk("R7 byte address", cmd_addr, {wa, (m == 2)});
        chk("R7 data", cmd_data, (m == 0) ? wd : {8'h00, wd[7:0]});
        chk("R7 byte flag", cmd_byte, (m != 0));
        chk("R8 bank", cmd_bank, wa[7:6]);
        @(negedge clk);
        chk("R7 strobe single", cmd_valid, 0);
      end
    end

    // R5 R6: illegal and deselected combinations, both widths
    for (int wdm = 0; wdm < 2; wdm++) begin
      for (int k = 0; k < 5; k++) begin
        case (k)
          0: pins(1, 0, 0, wdm[0], 8'h55, 16'hFFFF);
          1: pins(1, 0, 1, wdm[0], 8'h55, 16'hFFFF);
          2: pins(1, 1, 0, wdm[0], 8'h55, 16'hFFFF);
          3: pins(1, 1, 1, wdm[0], 8'h55, 16'hFFFF);
          default: pins(0, 0, 0, wdm[0], 8'h55, 16'hFFFF);
        endcase
        repeat (2) begin
          @(negedge clk);
          chk("R6 no lane enabled", dq_oe, 0);
          chk("R6 no strobe", cmd_valid, 0);
        end
      end
      pins(1, 1, 1, 1, '0, '0);
      @(negedge clk);
      chk("R6 no strobe after clash", cmd_valid, 0);
    end

    // R5: byte-mode write and idle keep upper lanes off
    pins(0, 1, 0, 0, 8'hC3, 16'h80AA);
    @(negedge clk);
    chk("R5 upper lanes off in byte write", dq_oe[15:8], 0);
    pins(1, 1, 1, 0, 8'hC3, 16'h8000);
    @(negedge clk);
    chk("R5 upper lanes off in byte idle", dq_oe[15:8], 0);
    chk("R8 bank of byte write", cmd_bank, 2'b11);

    pins(1, 1, 1, 1, '0, '0);
    @(negedge clk);
    finish_run();
  end
endmodule